// File: doc/BRIEF.md
# I2C Target Controller with Host-Requested NACK

This block is the target side of an I2C bus. It watches the open-drain clock and data lines, which arrive already synchronised, and detects START, repeated START and STOP. It compares each 7-bit address against a programmable own address. It shifts data bytes in and out and drives the acknowledge bit. A small register-style host port gives firmware an enable, a received-byte register, a transmit register and a set of status flags. The three event flags are combined into one interrupt line.

By default every received byte is acknowledged. Firmware can refuse the current incoming byte by setting a one-shot refusal request bit. The controller then releases SDA during that byte's acknowledge clock. It clears the request itself once that refusal clock has ended, when a STOP is seen, when a new own-address match occurs, or while the controller is disabled. This allows a combined transfer to be handled: a write of a register index, then a repeated START with a read address. Turning the enable off and back on flushes any transfer that the master abandoned without a STOP.

In a read transfer, the controller holds SCL low after each acknowledged byte until the host supplies the next byte. A master NACK ends the transmit phase.

Top module: `i2c_tgt`

## Requirements
- R1: Register map. CTRL is at offset 0: bit0 is the enable and bit1 is the refusal request. OWN is at offset 1, bits 6:0, and resets to OWN_ADDR_RST. After a START, an address byte whose upper 7 bits equal OWN is acknowledged (SDA low in the 9th clock), sets the match flag (FLAGS offset 2, bit0) and stores the R/W bit as the direction flag (bit5). Any other address gets no acknowledge and no flag.
- R2: In a write transfer with the request bit at 0, each byte is received MSB first and acknowledged. The byte appears in RXDATA (offset 3) and sets the receive flag (FLAGS bit1).
- R3: With the request bit at 1, the next completed received byte is stored but not acknowledged. The request bit reads 0 once that acknowledge clock has ended. Later bytes of that transfer get no acknowledge and leave RXDATA unchanged.
- R4: A STOP clears the request bit.
- R5: An own-address match clears the request bit. In a combined transfer (write address, index byte, repeated START, read address), the read-direction match raises the match flag again and sets the direction flag.
- R6: BUSY (FLAGS bit4) is 1 from a START until a STOP. It stays 1 if the master never sends STOP.
- R7: While the enable is 0, BUSY and the request bit are 0, the event flags are 0, TX-empty (FLAGS bit2) is 1, and neither line is driven. A write of the request bit while disabled has no effect. Re-enabling starts from idle.
- R8: After a read-address acknowledge, or after a master-acknowledged transmitted byte, SCL is held low until TXDATA (offset 4) is written. Writing TXDATA clears TX-empty. The byte is taken at once, so TX-empty returns to 1, and the byte is sent MSB first.
- R9: A master NACK on a transmitted byte ends transmission. SDA and SCL are released until the next START or STOP, even if TXDATA is written.
- R10: A repeated START or STOP in the middle of a byte abandons it. RXDATA and the receive flag are left unchanged, and a new address phase follows a repeated START.
- R11: The match, receive and STOP flags (FLAGS bit3; STOP sets it only while BUSY) clear when 1 is written to their bit. The irq output is high while any of these three flags is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 3 | Host register offset |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for host_addr (combinational) |
| irq | output | 1 | Combined event interrupt |
| scl_i | input | 1 | Synchronised SCL line level |
| sda_i | input | 1 | Synchronised SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The bench builds the controller with OWN_ADDR_RST = 7'h2C instead of the default 7'h42. This shows that the reset value comes from the parameter, and the reset address is then also the one that the first transfers match. Later the host reprograms OWN to 7'h51. This brings in reach both the register-selected match and the rejection of the old reset address. The 8-bit byte width lets the bench place a repeated START or STOP after a chosen number of bits, so mid-byte aborts are reachable.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int BYTE_W    = 8;
    localparam int ADDR_W    = 7;
    localparam int CNT_W     = $clog2(BYTE_W + 1);
    localparam int REG_AW    = 3;

    localparam logic [REG_AW-1:0] RA_CTRL  = 3'd0;
    localparam logic [REG_AW-1:0] RA_OWN   = 3'd1;
    localparam logic [REG_AW-1:0] RA_FLAGS = 3'd2;
    localparam logic [REG_AW-1:0] RA_RXD   = 3'd3;
    localparam logic [REG_AW-1:0] RA_TXD   = 3'd4;

    localparam int CB_EN   = 0;
    localparam int CB_NACK = 1;

    localparam int FB_HIT  = 0;
    localparam int FB_RXF  = 1;
    localparam int FB_TXE  = 2;
    localparam int FB_STOP = 3;
    localparam int FB_BUSY = 4;
    localparam int FB_DIR  = 5;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ADDR,
        S_ADDR_ACK,
        S_RX,
        S_RX_ACK,
        S_TX_WAIT,
        S_TX,
        S_TX_ACK,
        S_DONE
    } tgt_state_t;

    typedef struct packed {
        logic stop_seen;
        logic rx_full;
        logic addr_hit;
    } evt_flags_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_ev_t;

    function automatic logic [BYTE_W-1:0] pack_flags(evt_flags_t f, logic txe,
                                                     logic busy, logic dir);
        logic [BYTE_W-1:0] v;
        v          = '0;
        v[FB_HIT]  = f.addr_hit;
        v[FB_RXF]  = f.rx_full;
        v[FB_TXE]  = txe;
        v[FB_STOP] = f.stop_seen;
        v[FB_BUSY] = busy;
        v[FB_DIR]  = dir;
        return v;
    endfunction

endpackage

// File: rtl/i2c_tgt_cond.sv
module i2c_tgt_cond
    import i2c_tgt_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t bev
);

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    // SDA moving while SCL stays high marks a bus condition
    always_comb begin
        bev.start = scl_i & scl_q & sda_q & ~sda_i;
        bev.stop  = scl_i & scl_q & ~sda_q & sda_i;
        bev.rise  = scl_i & ~scl_q;
        bev.fall  = ~scl_i & scl_q;
    end

endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
    import i2c_tgt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  bus_ev_t           bev,
    input  logic              sda_i,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              nack_req,
    input  logic              tx_empty,
    input  logic [BYTE_W-1:0] tx_data,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic              busy,
    output logic              dir,
    output logic [BYTE_W-1:0] shreg,
    output logic              ev_addr,
    output logic              ev_rx,
    output logic              ev_nack_done,
    output logic              ev_stop,
    output logic              tx_take
);

    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

    tgt_state_t       state;
    logic [CNT_W-1:0] cnt;
    logic             ack_drv;
    logic             mack;
    logic             addr_eq;

    assign addr_eq = (shreg[BYTE_W-1 -: ADDR_W] == own_addr);

    always_comb begin
        ev_addr      = (state == S_ADDR) && bev.fall && (cnt == CNT_FULL) && addr_eq;
        ev_rx        = (state == S_RX) && bev.fall && (cnt == CNT_FULL);
        ev_nack_done = (state == S_RX_ACK) && bev.fall && !ack_drv;
        ev_stop      = en && bev.stop && busy;
        tx_take      = (state == S_TX_WAIT) && !tx_empty;
    end

    always_comb begin
        scl_oe = (state == S_TX_WAIT);
        sda_oe = (state == S_ADDR_ACK)
               | ((state == S_RX_ACK) & ack_drv)
               | ((state == S_TX) & ~shreg[BYTE_W-1]);
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            state   <= S_IDLE;
            busy    <= 1'b0;
            cnt     <= '0;
            shreg   <= '0;
            dir     <= 1'b0;
            ack_drv <= 1'b0;
            mack    <= 1'b0;
        end else if (bev.stop) begin
            state <= S_IDLE;
            busy  <= 1'b0;
        end else if (bev.start) begin
            state <= S_ADDR;
            busy  <= 1'b1;
            cnt   <= '0;
        end else begin
            case (state)
                S_ADDR: begin
                    if (bev.rise && cnt != CNT_FULL) begin
                        shreg <= {shreg[BYTE_W-2:0], sda_i};
                        cnt   <= cnt + 1'b1;
                    end else if (bev.fall && cnt == CNT_FULL) begin
                        if (addr_eq) begin
                            state <= S_ADDR_ACK;
                            dir   <= shreg[0];
                        end else begin
                            state <= S_DONE;
                        end
                    end
                end
                S_ADDR_ACK: begin
                    if (bev.fall) begin
                        cnt   <= '0;
                        state <= dir ? S_TX_WAIT : S_RX;
                    end
                end
                S_RX: begin
                    if (bev.rise && cnt != CNT_FULL) begin
                        shreg <= {shreg[BYTE_W-2:0], sda_i};
                        cnt   <= cnt + 1'b1;
                    end else if (bev.fall && cnt == CNT_FULL) begin
                        state   <= S_RX_ACK;
                        ack_drv <= !nack_req;
                    end
                end
                S_RX_ACK: begin
                    if (bev.fall) begin
                        cnt   <= '0;
                        state <= ack_drv ? S_RX : S_DONE;
                    end
                end
                S_TX_WAIT: begin
                    if (!tx_empty) begin
                        shreg <= tx_data;
                        cnt   <= '0;
                        state <= S_TX;
                    end
                end
                S_TX: begin
                    if (bev.fall) begin
                        shreg <= {shreg[BYTE_W-2:0], 1'b1};
                        if (cnt == CNT_LAST) begin
                            state <= S_TX_ACK;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                S_TX_ACK: begin
                    if (bev.rise) begin
                        mack <= sda_i;
                    end else if (bev.fall) begin
                        state <= mack ? S_DONE : S_TX_WAIT;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/i2c_tgt_regs.sv
module i2c_tgt_regs
    import i2c_tgt_pkg::*;
#(
    parameter logic [ADDR_W-1:0] OWN_ADDR_RST = 7'h42
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [REG_AW-1:0] host_addr,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic [BYTE_W-1:0] host_rdata,
    output logic              irq,
    input  logic              stop_det,
    input  logic              ev_addr,
    input  logic              ev_rx,
    input  logic              ev_nack_done,
    input  logic              ev_stop,
    input  logic              tx_take,
    input  logic              busy,
    input  logic              dir,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              en,
    output logic              nack_req,
    output logic [ADDR_W-1:0] own_addr,
    output logic [BYTE_W-1:0] tx_data,
    output logic              tx_empty,
    output logic [BYTE_W-1:0] rx_data
);

    evt_flags_t flags;

    always_ff @(posedge clk) begin
        if (rst) begin
            en       <= 1'b0;
            nack_req <= 1'b0;
            own_addr <= OWN_ADDR_RST;
            tx_data  <= '0;
            tx_empty <= 1'b1;
            rx_data  <= '0;
            flags    <= '0;
        end else begin
            if (host_we) begin
                case (host_addr)
                    RA_CTRL: begin
                        en <= host_wdata[CB_EN];
                        if (host_wdata[CB_NACK] && en) nack_req <= 1'b1;
                    end
                    RA_OWN: own_addr <= host_wdata[ADDR_W-1:0];
                    RA_FLAGS: begin
                        if (host_wdata[FB_HIT])  flags.addr_hit  <= 1'b0;
                        if (host_wdata[FB_RXF])  flags.rx_full   <= 1'b0;
                        if (host_wdata[FB_STOP]) flags.stop_seen <= 1'b0;
                    end
                    RA_TXD: begin
                        tx_data  <= host_wdata;
                        tx_empty <= 1'b0;
                    end
                    default: ;
                endcase
            end
            // bus events win over host writes in the same cycle
            if (ev_rx) begin
                rx_data       <= rx_byte;
                flags.rx_full <= 1'b1;
            end
            if (ev_addr) begin
                flags.addr_hit <= 1'b1;
                nack_req       <= 1'b0;
            end
            if (ev_nack_done || (stop_det && en)) nack_req <= 1'b0;
            if (ev_stop) flags.stop_seen <= 1'b1;
            if (tx_take) tx_empty <= 1'b1;
            if (!en) begin
                nack_req <= 1'b0;
                flags    <= '0;
                tx_empty <= 1'b1;
            end
        end
    end

    assign irq = |flags;

    always_comb begin
        host_rdata = '0;
        case (host_addr)
            RA_CTRL: begin
                host_rdata[CB_EN]   = en;
                host_rdata[CB_NACK] = nack_req;
            end
            RA_OWN:   host_rdata[ADDR_W-1:0] = own_addr;
            RA_FLAGS: host_rdata = pack_flags(flags, tx_empty, busy, dir);
            RA_RXD:   host_rdata = rx_data;
            default:  host_rdata = '0;
        endcase
    end

endmodule

// File: rtl/i2c_tgt.sv
module i2c_tgt
    import i2c_tgt_pkg::*;
#(
    parameter logic [ADDR_W-1:0] OWN_ADDR_RST = 7'h42
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [REG_AW-1:0] host_addr,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic [BYTE_W-1:0] host_rdata,
    output logic              irq,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe
);

    bus_ev_t           bev;
    logic              start_det;
    logic              stop_det;
    logic              en;
    logic              nack_req;
    logic [ADDR_W-1:0] own_addr;
    logic [BYTE_W-1:0] tx_data;
    logic              tx_empty;
    logic [BYTE_W-1:0] rx_data;
    logic              busy;
    logic              dir;
    logic [BYTE_W-1:0] shreg;
    logic              ev_addr;
    logic              ev_rx;
    logic              ev_nack_done;
    logic              ev_stop;
    logic              tx_take;

    assign start_det = bev.start;
    assign stop_det  = bev.stop;

    i2c_tgt_cond u_cond (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .bev   (bev)
    );

    i2c_tgt_engine u_engine (
        .clk          (clk),
        .rst          (rst),
        .en           (en),
        .bev          (bev),
        .sda_i        (sda_i),
        .own_addr     (own_addr),
        .nack_req     (nack_req),
        .tx_empty     (tx_empty),
        .tx_data      (tx_data),
        .scl_oe       (scl_oe),
        .sda_oe       (sda_oe),
        .busy         (busy),
        .dir          (dir),
        .shreg        (shreg),
        .ev_addr      (ev_addr),
        .ev_rx        (ev_rx),
        .ev_nack_done (ev_nack_done),
        .ev_stop      (ev_stop),
        .tx_take      (tx_take)
    );

    i2c_tgt_regs #(
        .OWN_ADDR_RST (OWN_ADDR_RST)
    ) u_regs (
        .clk          (clk),
        .rst          (rst),
        .host_we      (host_we),
        .host_addr    (host_addr),
        .host_wdata   (host_wdata),
        .host_rdata   (host_rdata),
        .irq          (irq),
        .stop_det     (stop_det),
        .ev_addr      (ev_addr),
        .ev_rx        (ev_rx),
        .ev_nack_done (ev_nack_done),
        .ev_stop      (ev_stop),
        .tx_take      (tx_take),
        .busy         (busy),
        .dir          (dir),
        .rx_byte      (shreg),
        .en           (en),
        .nack_req     (nack_req),
        .own_addr     (own_addr),
        .tx_data      (tx_data),
        .tx_empty     (tx_empty),
        .rx_data      (rx_data)
    );

endmodule

// File: rtl/i2c_tgt_chk.sv
module i2c_tgt_chk (
    input logic       clk,
    input logic       rst,
    input logic       en,
    input logic       nack_req,
    input logic       start_det,
    input logic       stop_det,
    input logic       ev_addr,
    input logic       ev_rx,
    input logic       ev_nack_done,
    input logic       busy,
    input logic       tx_empty,
    input logic [7:0] rx_data,
    input logic       scl_oe,
    input logic       sda_oe
);

    p_nack_after_drive_r3: assert property (@(posedge clk) disable iff (rst)
        ev_nack_done |=> !nack_req);

    p_nack_stop_r4: assert property (@(posedge clk) disable iff (rst)
        (en && stop_det) |=> !nack_req);

    p_nack_match_r5: assert property (@(posedge clk) disable iff (rst)
        ev_addr |=> !nack_req);

    p_busy_start_r6: assert property (@(posedge clk) disable iff (rst)
        (en && start_det) |=> busy);

    p_disable_flush_r7: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!busy && !nack_req && tx_empty));

    p_hold_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
        !(scl_oe && sda_oe));

    p_rx_stable_r10: assert property (@(posedge clk) disable iff (rst)
        !ev_rx |=> $stable(rx_data));

endmodule

bind i2c_tgt i2c_tgt_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .en           (en),
    .nack_req     (nack_req),
    .start_det    (start_det),
    .stop_det     (stop_det),
    .ev_addr      (ev_addr),
    .ev_rx        (ev_rx),
    .ev_nack_done (ev_nack_done),
    .busy         (busy),
    .tx_empty     (tx_empty),
    .rx_data      (rx_data),
    .scl_oe       (scl_oe),
    .sda_oe       (sda_oe)
);

// File: tb/i2c_tgt_bench.sv
`timescale 1ns/1ps
module i2c_tgt_bench;

    localparam logic [6:0] OWN = 7'h2C;
    localparam logic [6:0] NEW_OWN = 7'h51;
    localparam int HP = 8;
    localparam logic [2:0] A_CTRL = 3'd0, A_OWN = 3'd1, A_FLAGS = 3'd2,
                           A_RXD = 3'd3, A_TXD = 3'd4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic host_we = 1'b0;
    logic [2:0] host_addr = 3'd0;
    logic [7:0] host_wdata = 8'd0;
    logic [7:0] host_rdata;
    logic irq, scl_oe, sda_oe;
    logic m_scl_low = 1'b0;
    logic m_sda_low = 1'b0;
    logic scl_bus, sda_bus;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    assign scl_bus = ~(m_scl_low | scl_oe);
    assign sda_bus = ~(m_sda_low | sda_oe);

    always #2.5 clk = ~clk;

    i2c_tgt #(.OWN_ADDR_RST(OWN)) u_i2c_tgt (
        .clk        (clk),
        .rst        (rst),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .irq        (irq),
        .scl_i      (scl_bus),
        .sda_i      (sda_bus),
        .scl_oe     (scl_oe),
        .sda_oe     (sda_oe)
    );

    function automatic logic [7:0] exp_flags(logic hit, logic rxf, logic txe,
                                             logic stp, logic bsy, logic dr);
        return {2'b00, dr, bsy, stp, txe, rxf, hit};
    endfunction

    task automatic check8(string req, string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic hw(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic hr(logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic wait_scl_high();
        while (!scl_bus) @(negedge clk);
    endtask

    task automatic m_start();
        @(negedge clk);
        m_sda_low = 1'b1; idle(HP);
        m_scl_low = 1'b1; idle(HP);
    endtask

    task automatic m_rstart();
        m_sda_low = 1'b0; idle(HP);
        m_scl_low = 1'b0; wait_scl_high(); idle(HP);
        m_sda_low = 1'b1; idle(HP);
        m_scl_low = 1'b1; idle(HP);
    endtask

    task automatic m_stop();
        m_sda_low = 1'b1; idle(HP);
        m_scl_low = 1'b0; wait_scl_high(); idle(HP);
        m_sda_low = 1'b0; idle(HP);
    endtask

    task automatic m_bit(logic b, output logic r);
        m_sda_low = !b; idle(HP);
        m_scl_low = 1'b0; wait_scl_high(); idle(HP/2);
        r = sda_bus; idle(HP/2);
        m_scl_low = 1'b1; idle(HP);
    endtask

    task automatic m_wbyte(logic [7:0] d, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) m_bit(d[i], r);
        m_bit(1'b1, r);
        ack = !r;
    endtask

    task automatic m_rbyte(logic ack, output logic [7:0] d);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            m_bit(1'b1, r);
            d[i] = r;
        end
        m_bit(!ack, r);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd, b, prev, tb1, tb2;
        logic ack, dmy;
        void'($urandom(32'h00C0FFEE));
        idle(4);
        rst = 1'b0;
        idle(2);

        // reset state
        hr(A_CTRL, rd);  check8("R7", "reset ctrl", rd, 8'h00);
        hr(A_FLAGS, rd); check8("R7", "reset flags", rd, exp_flags(0,0,1,0,0,0));
        hr(A_OWN, rd);   check8("R1", "reset own address", rd, {1'b0, OWN});
        check8("R11", "reset irq/lines", {5'd0, irq, scl_oe, sda_oe}, 8'h00);

        hw(A_CTRL, 8'h01);

        // foreign address
        m_start();
        m_wbyte({7'h13, 1'b0}, ack);
        check8("R1", "foreign address ack", {7'd0, ack}, 8'h00);
        hr(A_FLAGS, rd); check8("R6", "busy after start", rd, exp_flags(0,0,1,0,1,0));
        m_stop();
        hr(A_FLAGS, rd); check8("R11", "stop flag", rd, exp_flags(0,0,1,1,0,0));
        check8("R11", "irq on stop", {7'd0, irq}, 8'h01);
        hw(A_FLAGS, 8'h08);
        hr(A_FLAGS, rd); check8("R11", "stop flag w1c", rd, exp_flags(0,0,1,0,0,0));
        check8("R11", "irq cleared", {7'd0, irq}, 8'h00);

        // write transfer with random bytes
        m_start();
        m_wbyte({OWN, 1'b0}, ack);
        check8("R1", "own address ack", {7'd0, ack}, 8'h01);
        hr(A_FLAGS, rd); check8("R1", "match flag write dir", rd, exp_flags(1,0,1,0,1,0));
        hw(A_FLAGS, 8'h01);
        for (int i = 0; i < 6; i++) begin
            b = 8'($urandom_range(0, 255));
            m_wbyte(b, ack);
            check8("R2", "data ack", {7'd0, ack}, 8'h01);
            hr(A_RXD, rd);   check8("R2", "rx data", rd, b);
            hr(A_FLAGS, rd); check8("R2", "rx flag", rd, exp_flags(0,1,1,0,1,0));
            hw(A_FLAGS, 8'h02);
        end

        // refusal request
        hw(A_CTRL, 8'h03);
        hr(A_CTRL, rd); check8("R3", "request set", rd, 8'h03);
        b = 8'($urandom_range(0, 255));
        m_wbyte(b, ack);
        check8("R3", "refused byte ack", {7'd0, ack}, 8'h00);
        hr(A_CTRL, rd); check8("R3", "request self-cleared", rd, 8'h01);
        hr(A_RXD, rd);  check8("R3", "refused byte stored", rd, b);
        prev = b;
        hw(A_FLAGS, 8'h02);
        m_wbyte(~b, ack);
        check8("R3", "following byte ack", {7'd0, ack}, 8'h00);
        hr(A_RXD, rd);   check8("R3", "following byte ignored", rd, prev);
        hr(A_FLAGS, rd); check8("R3", "no rx flag", rd, exp_flags(0,0,1,0,1,0));
        m_stop();
        hw(A_FLAGS, 8'h08);

        // STOP clears the request
        m_start();
        m_wbyte({OWN, 1'b0}, ack);
        hw(A_CTRL, 8'h03);
        hr(A_CTRL, rd); check8("R4", "request pending", rd, 8'h03);
        m_stop();
        hr(A_CTRL, rd); check8("R4", "stop clears request", rd, 8'h01);
        hw(A_FLAGS, 8'h0B);

        // combined transfer
        m_start();
        m_wbyte({OWN, 1'b0}, ack);
        hw(A_FLAGS, 8'h01);
        m_wbyte(8'($urandom_range(0, 255)), ack);
        check8("R5", "index ack", {7'd0, ack}, 8'h01);
        hw(A_FLAGS, 8'h02);
        hw(A_CTRL, 8'h03);
        m_rstart();
        m_wbyte({OWN, 1'b1}, ack);
        check8("R5", "read address ack", {7'd0, ack}, 8'h01);
        hr(A_CTRL, rd);  check8("R5", "match clears request", rd, 8'h01);
        hr(A_FLAGS, rd); check8("R5", "match flag read dir", rd, exp_flags(1,0,1,0,1,1));

        // transmit with clock hold
        idle(20);
        check8("R8", "scl held waiting for data", {6'd0, scl_oe, scl_bus}, 8'h02);
        hw(A_FLAGS, 8'h01);
        tb1 = 8'($urandom_range(0, 255));
        hw(A_TXD, tb1);
        idle(2);
        hr(A_FLAGS, rd); check8("R8", "tx taken", rd, exp_flags(0,0,1,0,1,1));
        m_rbyte(1'b1, rd);
        check8("R8", "tx byte 1", rd, tb1);
        idle(4);
        check8("R8", "scl held for next byte", {7'd0, scl_oe}, 8'h01);
        tb2 = 8'($urandom_range(0, 255));
        hw(A_TXD, tb2);
        m_rbyte(1'b0, rd);
        check8("R9", "tx byte 2", rd, tb2);
        idle(10);
        check8("R9", "lines released after master nack", {6'd0, scl_oe, sda_oe}, 8'h00);
        hw(A_TXD, 8'h00);
        idle(4);
        check8("R9", "no hold after master nack", {7'd0, scl_oe}, 8'h00);
        m_rbyte(1'b0, rd);
        check8("R9", "no data after master nack", rd, 8'hFF);

        // master abandons without STOP
        idle(100);
        hr(A_FLAGS, rd); check8("R6", "busy without stop", rd, exp_flags(0,0,0,0,1,1));

        // enable toggle flush
        hw(A_CTRL, 8'h00);
        hr(A_FLAGS, rd); check8("R7", "disabled flags", rd, exp_flags(0,0,1,0,0,0));
        hw(A_CTRL, 8'h02);
        hr(A_CTRL, rd);  check8("R7", "request ignored when off", rd, 8'h00);
        hw(A_CTRL, 8'h01);
        m_stop();
        hr(A_FLAGS, rd); check8("R7", "idle after re-enable", rd, exp_flags(0,0,1,0,0,0));
        check8("R7", "lines released", {6'd0, scl_oe, sda_oe}, 8'h00);

        // new own address and mid-byte aborts
        hw(A_OWN, {1'b0, NEW_OWN});
        m_start();
        m_wbyte({NEW_OWN, 1'b0}, ack);
        check8("R1", "new address ack", {7'd0, ack}, 8'h01);
        b = 8'($urandom_range(0, 255));
        m_wbyte(b, ack);
        hw(A_FLAGS, 8'h03);
        for (int i = 0; i < 4; i++) m_bit(1'($urandom_range(0, 1)), dmy);
        m_rstart();
        hr(A_RXD, rd);   check8("R10", "rstart mid-byte rx kept", rd, b);
        hr(A_FLAGS, rd); check8("R10", "rstart mid-byte flags", rd, exp_flags(0,0,1,0,1,0));
        m_wbyte({OWN, 1'b0}, ack);
        check8("R1", "old address refused", {7'd0, ack}, 8'h00);
        m_rstart();
        m_wbyte({NEW_OWN, 1'b0}, ack);
        check8("R10", "address phase after rstart", {7'd0, ack}, 8'h01);
        hw(A_FLAGS, 8'h01);
        for (int i = 0; i < 3; i++) m_bit(1'($urandom_range(0, 1)), dmy);
        m_stop();
        hr(A_RXD, rd);   check8("R10", "stop mid-byte rx kept", rd, b);
        hr(A_FLAGS, rd); check8("R10", "stop mid-byte flags", rd, exp_flags(0,0,1,1,0,0));

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule